// File: doc/BRIEF.md
# Data Segment Selector with Override Tracking

This unit chooses which of six segment registers supplies the base for a data access in a real-address-mode core, and forms the resulting 20-bit physical address. It keeps a small per-instruction mode register. Prefix decode sets one bit per segment-override prefix and two repeat-prefix bits. Address decode sets a stack-default bit when the addressing form is based on the base pointer or the stack pointer. The sequencer clears the whole register when an instruction retires. Prefixes are not instructions in this sense, so overrides seen in earlier prefix bytes stay in force until the instruction they qualify completes.

Selection is combinational from the registered mode and the live segment values. An explicit override always beats the implicit stack default. When neither is present, the data segment is used. Two or more override bits at once is an illegal state. The unit then flags an error, drives a zero segment, and raises a halt request that stays set until reset. The physical address is the selected segment times sixteen plus the 16-bit offset, and it wraps at 1 MiB.

Top module: `seg_select_unit`

## Requirements
- R1: After a synchronous active-low reset, the mode register is empty: `seg_val` equals `seg_ds`, `multi_ovr_err` and `halt_req` are 0, and `rep_flags` is 0.
- R2: With no override bit and no stack-default bit set, `seg_val` equals `seg_ds`.
- R3: With only the stack-default bit set, `seg_val` equals `seg_ss`.
- R4: With exactly one override bit set, `seg_val` is that segment, whatever the stack-default bit holds. The `ovr_req` bit positions are 0 = ES, 1 = CS, 2 = SS, 3 = DS, 4 = FS and 5 = GS.
- R5: With two or more override bits set, `multi_ovr_err` is 1 and `seg_val` is 0.
- R6: `halt_req` rises on the clock edge after a cycle in which `multi_ovr_err` is 1, and then stays at 1 until reset.
- R7: `phys_addr` equals (`seg_val` × 16 + `offset`) modulo 2^20.
- R8: A cycle with `instr_end` high clears the override, stack-default and repeat bits at the next edge. This takes priority over any strobe in the same cycle.
- R9: Without `instr_end`, strobes take effect at the next edge and are ORed into the bits already held, so several prefix cycles accumulate.
- R10: The repeat bits are shown on `rep_flags` (bit 0 = repeat-while-equal, bit 1 = repeat-while-not-equal) and have no effect on `seg_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seg_es | input | 16 | Extra segment register value |
| seg_cs | input | 16 | Code segment register value |
| seg_ss | input | 16 | Stack segment register value |
| seg_ds | input | 16 | Data segment register value |
| seg_fs | input | 16 | FS segment register value |
| seg_gs | input | 16 | GS segment register value |
| ovr_req | input | 6 | Override-prefix strobes, one bit per segment (R4 encoding) |
| stk_dflt_set | input | 1 | Address decode requests the stack segment as default |
| rep_req | input | 2 | Repeat-prefix strobes |
| instr_end | input | 1 | Instruction retired; clear the mode register |
| offset | input | 16 | Effective offset of the access |
| seg_val | output | 16 | Selected segment value |
| phys_addr | output | 20 | Physical address, wraps at 1 MiB |
| multi_ovr_err | output | 1 | More than one override bit is held |
| halt_req | output | 1 | Sticky halt request after an illegal override state |
| rep_flags | output | 2 | Held repeat-prefix bits |

## Verification
The assertions assume the reset is held low for at least one clock edge before any result is used. They make no assumption about how the strobes are combined, since any mix of `ovr_req`, `stk_dflt_set`, `rep_req` and `instr_end` is legal input, including an end strobe together with prefix strobes. The stimulus therefore starts with a reset of several cycles. Directed sequences then step through each override alone, the override and stack-default mix, and accumulation over several prefix cycles. After that, a long random run drives override strobes at a low rate while the other strobes and the segment and offset values vary freely, so both the legal single-override paths and the illegal multi-override path are reached.

// File: rtl/seg_sel_pkg.sv
// Package: shared constants and the per-instruction mode record for the
// segment selector. The segment index order is the bit order of the
// override strobe vector.
package seg_sel_pkg;
    localparam int NSEG  = 6;
    localparam int NREP  = 2;
    localparam int ES_IX = 0;
    localparam int CS_IX = 1;
    localparam int SS_IX = 2;
    localparam int DS_IX = 3;
    localparam int FS_IX = 4;
    localparam int GS_IX = 5;

    typedef struct packed {
        logic [NREP-1:0] rep;
        logic            stk;
        logic [NSEG-1:0] ovr;
    } mode_t;
endpackage

// File: rtl/seg_mode_reg.sv
// Module: seg_mode_reg
// Holds the override, stack-default and repeat bits for the instruction
// in flight, plus a sticky halt request.
// Assumes: instr_end marks a retired instruction (never a prefix byte);
// err_in is the combinational illegal-state flag from the selector.
module seg_mode_reg
    import seg_sel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSEG-1:0] ovr_req,
    input  logic            stk_set,
    input  logic [NREP-1:0] rep_req,
    input  logic            instr_end,
    input  logic            err_in,
    output mode_t           mode_q,
    output logic            halt_q
);

    // Mode bits: clear on reset or retire, otherwise accumulate strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || instr_end) begin
            mode_q <= '0;
        end else begin
            mode_q.ovr <= mode_q.ovr | ovr_req;
            mode_q.stk <= mode_q.stk | stk_set;
            mode_q.rep <= mode_q.rep | rep_req;
        end
    end

    // Halt request: latched on the first illegal state, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
        end else if (err_in) begin
            halt_q <= 1'b1;
        end
    end

    // R8
    end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_end |=> (mode_q == '0));

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_end |=> ((mode_q.ovr & $past(mode_q.ovr)) == $past(mode_q.ovr)));

    // R6
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |=> halt_q);

    // R6
    halt_follows_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_in |=> halt_q);

endmodule

// File: rtl/seg_pick.sv
// Module: seg_pick
// Combinational choice of the segment value from the held override and
// stack-default bits. A single override wins; none falls back to SS when
// the stack default is held, else DS; several give zero and an error.
// Assumes: segs is indexed per seg_sel_pkg.
module seg_pick
    import seg_sel_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic [NSEG-1:0][SEG_W-1:0] segs,
    input  logic [NSEG-1:0]            ovr,
    input  logic                       stk,
    output logic [SEG_W-1:0]           seg_val,
    output logic                       multi_err
);

    logic [NSEG-1:0][SEG_W-1:0] gated;
    logic [SEG_W-1:0]           ovr_val;
    logic                       any_ovr;

    // Mask each segment by its own override bit.
    generate
        for (genvar g = 0; g < NSEG; g++) begin : g_gate
            assign gated[g] = ovr[g] ? segs[g] : '0;
        end
    endgenerate

    // OR-combine the masked segments (exactly one is live when legal).
    always_comb begin
        ovr_val = '0;
        for (int i = 0; i < NSEG; i++) begin
            ovr_val = ovr_val | gated[i];
        end
    end

    assign any_ovr   = |ovr;
    assign multi_err = (ovr & (ovr - NSEG'(1))) != '0;

    // Final priority: error, explicit override, stack default, data.
    always_comb begin
        if (multi_err) begin
            seg_val = '0;
        end else if (any_ovr) begin
            seg_val = ovr_val;
        end else if (stk) begin
            seg_val = segs[SS_IX];
        end else begin
            seg_val = segs[DS_IX];
        end
    end

endmodule

// File: rtl/phys_addr_gen.sv
// Module: phys_addr_gen
// Forms segment * 2^SHIFT + offset and keeps the low PA_W bits.
// Assumes: PA_W does not exceed the internal sum width.
module phys_addr_gen #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20
) (
    input  logic [SEG_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  addr
);

    localparam int BASE_W = SEG_W + SHIFT;
    localparam int SUM_W  = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1;

    logic [SUM_W-1:0] full_sum;

    // Full-width sum, truncated so the address wraps at 2^PA_W.
    always_comb begin
        full_sum = (SUM_W'(seg) << SHIFT) + SUM_W'(off);
        addr     = full_sum[PA_W-1:0];
    end

endmodule

// File: rtl/seg_select_unit.sv
// Module: seg_select_unit (top)
// Per-instruction segment selection and physical address formation for
// data accesses. Mode bits are registered; selection and the address are
// combinational from the held bits and the live segment values.
// Assumes: reset held for at least one edge before outputs are used.
module seg_select_unit
    import seg_sel_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEG_W-1:0]  seg_es,
    input  logic [SEG_W-1:0]  seg_cs,
    input  logic [SEG_W-1:0]  seg_ss,
    input  logic [SEG_W-1:0]  seg_ds,
    input  logic [SEG_W-1:0]  seg_fs,
    input  logic [SEG_W-1:0]  seg_gs,
    input  logic [NSEG-1:0]   ovr_req,
    input  logic              stk_dflt_set,
    input  logic [NREP-1:0]   rep_req,
    input  logic              instr_end,
    input  logic [OFF_W-1:0]  offset,
    output logic [SEG_W-1:0]  seg_val,
    output logic [PA_W-1:0]   phys_addr,
    output logic              multi_ovr_err,
    output logic              halt_req,
    output logic [NREP-1:0]   rep_flags
);

    logic [NSEG-1:0][SEG_W-1:0] seg_vec;
    mode_t                      mode;

    // Pack the segment registers in package index order.
    always_comb begin
        seg_vec        = '0;
        seg_vec[ES_IX] = seg_es;
        seg_vec[CS_IX] = seg_cs;
        seg_vec[SS_IX] = seg_ss;
        seg_vec[DS_IX] = seg_ds;
        seg_vec[FS_IX] = seg_fs;
        seg_vec[GS_IX] = seg_gs;
    end

    seg_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovr_req   (ovr_req),
        .stk_set   (stk_dflt_set),
        .rep_req   (rep_req),
        .instr_end (instr_end),
        .err_in    (multi_ovr_err),
        .mode_q    (mode),
        .halt_q    (halt_req)
    );

    seg_pick #(.SEG_W(SEG_W)) u_pick (
        .segs      (seg_vec),
        .ovr       (mode.ovr),
        .stk       (mode.stk),
        .seg_val   (seg_val),
        .multi_err (multi_ovr_err)
    );

    phys_addr_gen #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT),
        .PA_W  (PA_W)
    ) u_addr (
        .seg  (seg_val),
        .off  (offset),
        .addr (phys_addr)
    );

    assign rep_flags = mode.rep;

    // R3
    stack_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.ovr == '0 && mode.stk) |-> (seg_val == seg_ss));

    // R5
    err_zero_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        multi_ovr_err |-> (seg_val == '0));

    // R2
    plain_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.ovr == '0 && !mode.stk) |-> (seg_val == seg_ds));

endmodule

// File: tb/sim_seg_select_unit.sv
`timescale 1ns/1ps
module sim_seg_select_unit;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic [15:0] s_es, s_cs, s_ss, s_ds, s_fs, s_gs, offset;
    logic [5:0]  ovr_req;
    logic        stk_dflt_set, instr_end;
    logic [1:0]  rep_req;
    logic [15:0] seg_val;
    logic [19:0] phys_addr;
    logic        multi_ovr_err, halt_req;
    logic [1:0]  rep_flags;

    seg_select_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .seg_es(s_es), .seg_cs(s_cs), .seg_ss(s_ss),
        .seg_ds(s_ds), .seg_fs(s_fs), .seg_gs(s_gs),
        .ovr_req(ovr_req), .stk_dflt_set(stk_dflt_set), .rep_req(rep_req),
        .instr_end(instr_end), .offset(offset),
        .seg_val(seg_val), .phys_addr(phys_addr),
        .multi_ovr_err(multi_ovr_err), .halt_req(halt_req), .rep_flags(rep_flags)
    );

    int tests = 0;
    int fails = 0;
    bit live  = 0;
    bit done  = 0;

    // Behavioural reference state
    bit [5:0] m_ovr;
    bit       m_stk;
    bit [1:0] m_rep;
    bit       m_halt;

    function automatic int popc(bit [5:0] v);
        int n = 0;
        for (int i = 0; i < 6; i++) n += v[i];
        return n;
    endfunction

    function automatic logic [15:0] seg_of(int ix);
        case (ix)
            0: return s_es;
            1: return s_cs;
            2: return s_ss;
            3: return s_ds;
            4: return s_fs;
            default: return s_gs;
        endcase
    endfunction

    function automatic logic [15:0] exp_seg();
        int n = popc(m_ovr);
        if (n > 1) return 16'h0;
        if (n == 1) begin
            for (int i = 0; i < 6; i++) if (m_ovr[i]) return seg_of(i);
        end
        return m_stk ? s_ss : s_ds;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare every output against the model
    task automatic cmp_all();
        string t;
        int n = popc(m_ovr);
        logic [15:0] es = exp_seg();
        logic [19:0] ea = 20'(({4'h0, es} << 4) + {4'h0, offset});
        if (n > 1)       t = "R5";
        else if (n == 1) t = "R4";
        else if (m_stk)  t = "R3";
        else             t = "R2";
        chk(t, "seg_val", 32'(seg_val), 32'(es));
        chk("R5", "multi_ovr_err", 32'(multi_ovr_err), 32'(n > 1));
        chk("R6", "halt_req", 32'(halt_req), 32'(m_halt));
        chk("R7", "phys_addr", 32'(phys_addr), 32'(ea));
        chk("R10", "rep_flags", 32'(rep_flags), 32'(m_rep));
    endtask

    // Reference update on each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ovr = '0; m_stk = 0; m_rep = '0; m_halt = 0;
        end else begin
            if (popc(m_ovr) > 1) m_halt = 1;
            if (instr_end) begin
                m_ovr = '0; m_stk = 0; m_rep = '0;
            end else begin
                m_ovr |= ovr_req; m_stk |= stk_dflt_set; m_rep |= rep_req;
            end
        end
    end

    task automatic rnd_segs();
        s_es = 16'($urandom); s_cs = 16'($urandom); s_ss = 16'($urandom);
        s_ds = 16'($urandom); s_fs = 16'($urandom); s_gs = 16'($urandom);
        offset = 16'($urandom);
    endtask

    task automatic drv(logic [5:0] o, logic s, logic [1:0] r, logic e);
        ovr_req = o; stk_dflt_set = s; rep_req = r; instr_end = e;
        @(negedge clk);
        if (live) cmp_all();
    endtask

    task automatic idle();
        drv(6'h0, 1'b0, 2'b00, 1'b0);
    endtask

    initial begin
        rst_n = 0;
        rnd_segs();
        ovr_req = '0; stk_dflt_set = 0; rep_req = '0; instr_end = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        live = 1;
        idle();
        // R1 reset state
        chk("R1", "seg_val", 32'(seg_val), 32'(s_ds));
        chk("R1", "err", 32'(multi_ovr_err), 0);
        chk("R1", "halt", 32'(halt_req), 0);
        chk("R1", "rep", 32'(rep_flags), 0);

        // R3 stack default alone, then R8 clear
        drv(6'h0, 1'b1, 2'b00, 1'b0);
        chk("R3", "seg_val", 32'(seg_val), 32'(s_ss));
        drv(6'h0, 1'b0, 2'b00, 1'b1);
        chk("R8", "seg_val after end", 32'(seg_val), 32'(s_ds));

        // R4 each override beats the stack default
        for (int ix = 0; ix < 6; ix++) begin
            rnd_segs();
            drv(6'(1 << ix), 1'b1, 2'b00, 1'b0);
            chk("R4", "override", 32'(seg_val), 32'(seg_of(ix)));
            idle();
            chk("R4", "override held", 32'(seg_val), 32'(seg_of(ix)));
            drv(6'h0, 1'b0, 2'b00, 1'b1);
        end

        // R9 accumulation over several prefix cycles
        drv(6'h0, 1'b1, 2'b00, 1'b0);
        drv(6'h0, 1'b0, 2'b01, 1'b0);
        chk("R9", "rep kept", 32'(rep_flags), 32'h1);
        chk("R9", "stk kept", 32'(seg_val), 32'(s_ss));
        drv(6'h08, 1'b0, 2'b00, 1'b0);
        chk("R9", "ds override on top", 32'(seg_val), 32'(s_ds));
        drv(6'h0, 1'b0, 2'b00, 1'b1);

        // R10 repeat bits do not move the selection
        drv(6'h0, 1'b0, 2'b11, 1'b0);
        chk("R10", "rep flags", 32'(rep_flags), 32'h3);
        chk("R10", "seg unaffected", 32'(seg_val), 32'(s_ds));

        // R8 end wins over same-cycle strobes
        drv(6'h01, 1'b1, 2'b11, 1'b1);
        chk("R8", "seg_val", 32'(seg_val), 32'(s_ds));
        chk("R8", "rep cleared", 32'(rep_flags), 0);

        // R7 address formation and wrap
        s_ds = 16'hFFFF; offset = 16'h0010;
        idle();
        chk("R7", "wrap", 32'(phys_addr), 32'h00000);
        s_ds = 16'h1234; offset = 16'h5678;
        idle();
        chk("R7", "sum", 32'(phys_addr), 32'h179B8);

        // R5 / R6 illegal double override
        drv(6'h03, 1'b0, 2'b00, 1'b0);
        chk("R5", "err", 32'(multi_ovr_err), 1);
        chk("R5", "seg zero", 32'(seg_val), 0);
        idle();
        chk("R6", "halt set", 32'(halt_req), 1);
        drv(6'h0, 1'b0, 2'b00, 1'b1);
        chk("R6", "halt sticky", 32'(halt_req), 1);
        chk("R5", "err gone", 32'(multi_ovr_err), 0);

        // Reset clears halt (R1)
        rst_n = 0;
        idle();
        rst_n = 1;
        idle();
        chk("R1", "halt after reset", 32'(halt_req), 0);

        // Random run
        for (int k = 0; k < 3000; k++) begin
            logic [5:0] o;
            rnd_segs();
            o = ($urandom_range(0, 7) == 0) ? 6'(1 << $urandom_range(0, 5)) : 6'h0;
            drv(o, 1'($urandom_range(0, 3) == 0), 2'($urandom),
                1'($urandom_range(0, 2) == 0));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule